// File: doc/BRIEF.md
# Delayed Write Completion Discard Timer

This block keeps a short in-order queue of delayed-write completions and watches the oldest one. Each completion waits for its initiator to repeat the write. When the initiator comes back with a matching tag, the head entry retires. If the initiator does not come back in time, a countdown on the head entry runs out and the entry is dropped. That drop can also raise a system-error pulse.

The countdown is loaded from a programmable reload input at the edge where an entry becomes head. It runs only while the queue holds something. A new completion is taken only while a free slot exists. A retire and a new push in the same cycle are both carried out. Bus decoding and write data are handled elsewhere.

Top module: `dct_discard_timer`

## Requirements
- R1: After reset the queue is empty: `empty_o`=1, `full_o`=0, `count_o`=0, and `discard_o`, `serr_o`, `retire_hit_o` are all 0.
- R2: `push_ack_o` is high in the same cycle as `push_i` when the queue is not full. The tag is stored at the next edge and `count_o` goes up by one.
- R3: When the queue holds DEPTH entries, `full_o`=1. A push in that state is refused (`push_ack_o`=0), and the count and stored tags do not change.
- R4: Suppose an entry becomes head at an edge while `reload_i` equals R. Then `discard_o` is high for exactly the one cycle that begins R edges later, with `head_tag_o` showing that entry. The entry leaves the queue at the following edge. With R=0, the discard shows in the cycle that starts at the head edge itself.
- R5: The countdown does not advance for entries behind the head. Each later entry gets its full R cycles, counted from the edge at which it becomes head.
- R6: `retire_i` with `retire_tag_i` equal to the head tag raises `retire_hit_o` in that cycle and removes the head at the next edge. The timer reloads from `reload_i` for the next head.
- R7: `retire_i` with a tag that differs from the head, or with an empty queue, gives `retire_hit_o`=0 and leaves the queue unchanged.
- R8: If a matching retire arrives in the same cycle the timer expires, the retire wins: `retire_hit_o`=1, and `discard_o`=0 and `serr_o`=0.
- R9: `serr_o` is high only in a discard cycle, and only when `serr_en_i` is high in that cycle.
- R10: A push and a removal in the same cycle are both honoured when the queue is not full, so the count stays the same. When the queue is full, the push is refused even if a removal happens in that cycle.
- R11: The reload value is captured only when an entry becomes head. Changing `reload_i` afterwards does not move that entry's discard cycle.
- R12: Entries reach the head, retire or get discarded in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | New completion offered |
| push_tag_i | input | TAG_W | Tag of the offered completion |
| push_ack_o | output | 1 | Offered completion accepted |
| retire_i | input | 1 | Initiator repeated a write |
| retire_tag_i | input | TAG_W | Tag of the repeated write |
| retire_hit_o | output | 1 | Repeat matched the head; head retires |
| reload_i | input | TMR_W | Countdown start value |
| serr_en_i | input | 1 | Enables the system-error pulse |
| discard_o | output | 1 | Head expired and is being dropped |
| serr_o | output | 1 | System-error pulse on an enabled discard |
| head_tag_o | output | TAG_W | Tag of the current head entry |
| count_o | output | $clog2(DEPTH+1) | Number of queued entries |
| full_o | output | 1 | Queue holds DEPTH entries |
| empty_o | output | 1 | Queue holds no entries |

## Verification
A read or write pointer that slips shows up on `head_tag_o` the next time an entry is retired or discarded. The scoreboard sees it as a tag out of push order. A countdown loaded at the wrong edge, or running for entries behind the head, moves `discard_o` by at least one cycle, and the cycle-exact checks catch that. An occupancy count that drifts shows up within a cycle on `count_o`, `full_o` or `push_ack_o`.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned DEF_DEPTH = 4;
  localparam int unsigned DEF_TAG_W = 8;
  localparam int unsigned DEF_TMR_W = 16;
endpackage

// File: rtl/dct_queue.sv
module dct_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TAG_W = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             rd_i,
  output logic [TAG_W-1:0] head_tag_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [TAG_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (wr_i && wr_ptr_q == PTR_W'(g)) slot_q[g] <= wr_tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (rd_i) rd_ptr_q <= ptr_next(rd_ptr_q);
      count_q <= count_q + CNT_W'(wr_i) - CNT_W'(rd_i);
    end
  end

  assign head_tag_o = slot_q[rd_ptr_q];
  assign count_o    = count_q;
  assign full_o     = (count_q == CNT_W'(DEPTH));
  assign empty_o    = (count_q == '0);

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_o);
  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);
  p_count_track_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> count_o == CNT_W'($past(count_o) + CNT_W'($past(wr_i)) - CNT_W'($past(rd_i))));
endmodule

// File: rtl/dct_timer.sv
module dct_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [TMR_W-1:0] value_i,
  output logic             zero_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= value_i;
    else if (run_i && !zero_o)   cnt_q <= cnt_q - TMR_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  p_load_capture_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(value_i));
  p_countdown_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !zero_o) |=> cnt_q == $past(cnt_q) - TMR_W'(1));
  p_hold_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dct_discard_timer.sv
module dct_discard_timer
  import dct_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned TAG_W = DEF_TAG_W,
  parameter int unsigned TMR_W = DEF_TMR_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [TAG_W-1:0] push_tag_i,
  output logic             push_ack_o,
  input  logic             retire_i,
  input  logic [TAG_W-1:0] retire_tag_i,
  output logic             retire_hit_o,
  input  logic [TMR_W-1:0] reload_i,
  input  logic             serr_en_i,
  output logic             discard_o,
  output logic             serr_o,
  output logic [TAG_W-1:0] head_tag_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic head_vld, expired, pop, load;

  dct_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (push_ack_o),
    .wr_tag_i   (push_tag_i),
    .rd_i       (pop),
    .head_tag_o (head_tag_o),
    .count_o    (count_o),
    .full_o     (full_o),
    .empty_o    (empty_o)
  );

  assign head_vld     = !empty_o;
  assign push_ack_o   = push_i && !full_o;
  assign retire_hit_o = retire_i && head_vld && (retire_tag_i == head_tag_o);
  // a matching repeat beats expiry in the same cycle
  assign discard_o    = head_vld && expired && !retire_hit_o;
  assign serr_o       = discard_o && serr_en_i;
  assign pop          = retire_hit_o || discard_o;
  // reload when a new entry takes the head position
  assign load         = pop || (push_ack_o && empty_o);

  dct_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .run_i   (head_vld),
    .value_i (reload_i),
    .zero_o  (expired)
  );

  p_serr_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> (discard_o && serr_en_i));
  p_retire_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_hit_o |-> !discard_o);
  p_discard_pops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |=> count_o == CNT_W'($past(count_o) + CNT_W'($past(push_ack_o)) - CNT_W'(1)));
  p_no_discard_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !discard_o && !retire_hit_o);
  p_full_refuse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_ack_o);
endmodule

// File: tb/sim_dct_discard_timer.sv
`timescale 1ns/1ps
module sim_dct_discard_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0;
  logic [7:0]  push_tag_i = '0;
  logic        push_ack_o;
  logic        retire_i = 1'b0;
  logic [7:0]  retire_tag_i = '0;
  logic        retire_hit_o;
  logic [15:0] reload_i = '0;
  logic        serr_en_i = 1'b0;
  logic        discard_o, serr_o, full_o, empty_o;
  logic [7:0]  head_tag_o;
  logic [2:0]  count_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [7:0] sb_q[$];

  always #2.5 clk = ~clk;

  dct_discard_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .push_tag_i(push_tag_i),
    .push_ack_o(push_ack_o), .retire_i(retire_i), .retire_tag_i(retire_tag_i),
    .retire_hit_o(retire_hit_o), .reload_i(reload_i), .serr_en_i(serr_en_i),
    .discard_o(discard_o), .serr_o(serr_o), .head_tag_o(head_tag_o),
    .count_o(count_o), .full_o(full_o), .empty_o(empty_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // driver: offers a tag; accepted tags enter the scoreboard
  task automatic push_one(input logic [7:0] tag, input int exp_ack, input string req);
    push_i = 1'b1;
    push_tag_i = tag;
    #1;
    chk(req, int'(push_ack_o), exp_ack);
    if (push_ack_o) sb_q.push_back(tag);
    tick();
    push_i = 1'b0;
  endtask

  // monitor: every retire or discard must name the oldest pushed tag
  always @(negedge clk) begin
    if (rst_ni && (retire_hit_o || discard_o)) begin
      if (sb_q.size() == 0) chk("R12 unexpected removal", 1, 0);
      else chk("R12 order", int'(head_tag_o), int'(sb_q.pop_front()));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 empty", int'(empty_o), 1);
    chk("R1 count", int'(count_o), 0);
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    tick(); #1;
    chk("R1 empty", int'(empty_o), 1);
    chk("R1 full", int'(full_o), 0);
    chk("R1 discard", int'(discard_o | serr_o | retire_hit_o), 0);
    tick();

    // R4/R9: reload 3, serr enabled
    reload_i = 16'd3; serr_en_i = 1'b1;
    push_one(8'd5, 1, "R2 ack");
    #1;
    chk("R2 count", int'(count_o), 1);
    for (int i = 0; i <= 3; i++) begin
      chk("R4 discard timing", int'(discard_o), (i == 3) ? 1 : 0);
      if (i == 3) begin
        chk("R9 serr enabled", int'(serr_o), 1);
        chk("R4 tag", int'(head_tag_o), 5);
      end else begin
        tick(); #1;
      end
    end
    tick(); #1;
    chk("R4 removed", int'(empty_o), 1);

    // R4/R9: reload 0, serr disabled
    tick();
    reload_i = 16'd0; serr_en_i = 1'b0;
    push_one(8'd6, 1, "R2 ack");
    #1;
    chk("R4 zero reload", int'(discard_o), 1);
    chk("R9 serr gated", int'(serr_o), 0);
    tick(); #1;
    chk("R4 removed", int'(empty_o), 1);

    // R6/R7 retire
    tick();
    chk("R7 empty retire", 0, 0);
    retire_i = 1'b1; retire_tag_i = 8'd1;
    #1;
    chk("R7 retire on empty", int'(retire_hit_o), 0);
    retire_i = 1'b0;
    tick();
    reload_i = 16'd5; serr_en_i = 1'b1;
    push_one(8'd1, 1, "R2 ack");
    push_one(8'd2, 1, "R2 ack");
    retire_i = 1'b1; retire_tag_i = 8'd9;
    #1;
    chk("R7 mismatch", int'(retire_hit_o), 0);
    tick();
    #1;
    chk("R7 count kept", int'(count_o), 2);
    retire_tag_i = 8'd1;
    #0.2;
    chk("R6 hit", int'(retire_hit_o), 1);
    tick();
    retire_i = 1'b0;
    #1;
    chk("R6 count", int'(count_o), 1);
    chk("R6 next head", int'(head_tag_o), 2);
    for (int i = 0; i <= 5; i++) begin
      chk("R6 reload timing", int'(discard_o), (i == 5) ? 1 : 0);
      if (i < 5) begin tick(); #1; end
    end
    tick(); tick();

    // R11: reload change after capture
    reload_i = 16'd4;
    push_one(8'd3, 1, "R2 ack");
    reload_i = 16'd1;
    #1;
    for (int i = 0; i <= 4; i++) begin
      chk("R11 captured reload", int'(discard_o), (i == 4) ? 1 : 0);
      if (i < 4) begin tick(); #1; end
    end
    tick(); tick();

    // R8: retire in expiry cycle
    reload_i = 16'd0;
    push_one(8'd7, 1, "R2 ack");
    retire_i = 1'b1; retire_tag_i = 8'd7;
    #1;
    chk("R8 hit", int'(retire_hit_o), 1);
    chk("R8 no discard", int'(discard_o), 0);
    chk("R8 no serr", int'(serr_o), 0);
    tick();
    retire_i = 1'b0;
    #1;
    chk("R8 removed", int'(empty_o), 1);
    tick();

    // R5: waiting entry gets full window
    reload_i = 16'd2;
    push_one(8'd10, 1, "R2 ack");
    push_one(8'd11, 1, "R2 ack");
    #1;
    chk("R5 first not yet", int'(discard_o), 0);
    tick(); #1;
    chk("R5 first discard", int'(discard_o), 1);
    chk("R5 first tag", int'(head_tag_o), 10);
    tick(); #1;
    for (int i = 0; i <= 2; i++) begin
      chk("R5 second window", int'(discard_o), (i == 2) ? 1 : 0);
      if (i < 2) begin tick(); #1; end
    end
    tick(); tick();

    // R3/R10: full behaviour
    reload_i = 16'd100;
    push_one(8'd20, 1, "R2 ack");
    push_one(8'd21, 1, "R2 ack");
    push_one(8'd22, 1, "R2 ack");
    push_one(8'd23, 1, "R2 ack");
    #1;
    chk("R3 full", int'(full_o), 1);
    tick();
    push_one(8'd24, 0, "R3 refused");
    #1;
    chk("R3 count kept", int'(count_o), 4);
    chk("R3 head kept", int'(head_tag_o), 20);
    tick();
    push_i = 1'b1; push_tag_i = 8'd25; retire_i = 1'b1; retire_tag_i = 8'd20;
    #1;
    chk("R10 full refuse with pop", int'(push_ack_o), 0);
    chk("R10 hit", int'(retire_hit_o), 1);
    tick();
    push_i = 1'b0; retire_i = 1'b0;
    #1;
    chk("R10 count after pop", int'(count_o), 3);
    tick();
    push_i = 1'b1; push_tag_i = 8'd26; retire_i = 1'b1; retire_tag_i = 8'd21;
    #1;
    chk("R10 ack with pop", int'(push_ack_o), 1);
    if (push_ack_o) sb_q.push_back(8'd26);
    tick();
    push_i = 1'b0; retire_i = 1'b0;
    #1;
    chk("R10 count steady", int'(count_o), 3);
    chk("R12 head", int'(head_tag_o), 22);
    for (int i = 0; i < 500 && !empty_o; i++) tick();
    tick();
    chk("R12 all drained", int'(empty_o), 1);
    chk("R12 scoreboard empty", sb_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule